// File: doc/BRIEF.md
# Passive Parallel Configuration Sequencer

This block runs the pin handshake that takes a target device from power-on through a full passive-parallel configuration and into user mode. A one-cycle `start_i` pulse launches a fixed sequence. The sequence checks the mode-select strap and waits for the target's open-drain control lines to settle. It then takes over the configuration pins, pulses the target's configuration reset, and checks that the target is ready for data.

When the checks pass, the block opens the configuration data and control paths and raises `stream_go_o`. The external data path pushes the bitstream, then pulses `stream_done_i`. The sequencer waits for the done line and issues a burst of extra configuration clocks. It then waits for user mode, releases every pin it took over, and makes a final sanity check.

Every wait has a cycle-count timeout. Every failed check ends the run with its own error code on `err_code_o`, and `done_o` marks the end of the run. All status inputs pass through multi-flop synchronizers before the state machine looks at them.

Top module: `ppcfg_seq`

## Requirements
- R1: One cycle after a `start_i` pulse, the synchronized 3-bit mode select is checked. Values 0 and 1 let the sequence proceed. Any other value ends the run with error code 1.
- R2: Before driving any pin, the block waits for both the nCONFIG pin and nSTATUS to read high. It makes the same wait again after chip enable goes low. A wait that lasts `TIMEOUT_CYC` cycles ends the run with code 2 (first wait) or code 3 (second wait).
- R3: Whenever chip enable `nce_o` is low (asserted), the config and nCONFIG override not-enables are 0 and the nSTATUS and CONF_DONE not-enables are 1. The overrides are applied one cycle before chip enable goes low.
- R4: The reset pulse drives `nconfig_o` low and waits for nSTATUS low (timeout: code 4). It then drives `nconfig_o` high and waits for nSTATUS high (timeout: code 5). `nconfig_o` is low only while chip enable is asserted.
- R5: After the reset pulse, CONF_DONE reading high ends the run with code 6. If CONF_DONE is low but its output-enable status reads low, the run ends with code 7.
- R6: With both path enables high, `stream_go_o` is held until `stream_done_i` pulses. The block then waits for CONF_DONE high. nSTATUS low during that wait ends the run with code 8. A timeout ends it with code 9.
- R7: After CONF_DONE, `dclk_pulse_o` is high for exactly `EXTRA_CLKS` (default 15) consecutive cycles. The block then waits for user mode, and a timeout ends the run with code 10.
- R8: After user mode, both path enables drop, all override not-enables return to 1 and chip enable goes high. The run then ends with code 0 if user mode, CONF_DONE and nSTATUS are all high, and with code 11 otherwise.
- R9: When a run ends, `done_o` is high, `busy_o` is low, and all driven pins are in the released state until the next start. The released state is: nCONFIG high, chip enable high, all not-enables 1, path enables low.
- R10: A `start_i` pulse while `busy_o` is high has no effect. A busy run always ends in `done_o`.
- R11: After reset, `busy_o`, `done_o` and `err_code_o` are 0 and the pins are in the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle launch pulse |
| stream_done_i | input | 1 | Pulse from the data path: the bitstream has been sent |
| msel_i | input | 3 | Mode-select strap (asynchronous) |
| nconfig_pin_i | input | 1 | nCONFIG pin readback (asynchronous) |
| nstatus_pin_i | input | 1 | nSTATUS pin readback (asynchronous) |
| condone_pin_i | input | 1 | CONF_DONE pin readback (asynchronous) |
| condone_oe_i | input | 1 | CONF_DONE output-enable status (asynchronous) |
| usermode_i | input | 1 | Target reports user mode (asynchronous) |
| nconfig_o | output | 1 | Driven nCONFIG level |
| nce_o | output | 1 | Chip enable, active low |
| nen_config_o | output | 1 | Config override not-enable |
| nen_nconfig_o | output | 1 | nCONFIG override not-enable |
| nen_nstatus_o | output | 1 | nSTATUS override not-enable |
| nen_condone_o | output | 1 | CONF_DONE override not-enable |
| en_cfg_ctrl_o | output | 1 | Configuration control path enable |
| en_cfg_data_o | output | 1 | Configuration data path enable |
| stream_go_o | output | 1 | Data streaming may proceed |
| dclk_pulse_o | output | 1 | One extra configuration clock per cycle high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Run finished (held until next start) |
| err_code_o | output | 4 | 0 on success, else the failing check's code |

## Verification
All pin outputs decode directly from the state register, so each one changes in the cycle after the edge that moves the state. Status inputs reach a decision only two synchronizer cycles after they move. The target model in the bench adds its own delay on top of that.

The bench therefore does not predict exact edges. It samples on falling edges and polls `done_o` up to a cap well past the timeout. It then compares the end code and the released pin state. The target model counts the extra clocks, so a short or long burst shows up either as a count mismatch or as a user-mode timeout.

Timeout runs are also measured from the start pulse and must last at least `TIMEOUT_CYC` cycles.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

    localparam int MSEL_W = 3;
    localparam int CODE_W = 4;

    typedef enum logic [4:0] {
        S_IDLE, S_CHK_MSEL, S_WAIT_PRE, S_OVR, S_CE_LOW, S_WAIT_POST,
        S_RST_LOW, S_RST_HIGH, S_CHK_CD, S_STREAM, S_WAIT_CD, S_DCLK,
        S_WAIT_UM, S_TEARDOWN, S_FINAL, S_DONE, S_FAIL
    } seq_state_e;

    typedef enum logic [CODE_W-1:0] {
        E_NONE       = 4'd0,
        E_MSEL       = 4'd1,
        E_PRE_PINS   = 4'd2,
        E_POST_PINS  = 4'd3,
        E_NSTS_LOW   = 4'd4,
        E_NSTS_HIGH  = 4'd5,
        E_CD_HIGH    = 4'd6,
        E_CD_OE      = 4'd7,
        E_NSTS_DROP  = 4'd8,
        E_CD_TMO     = 4'd9,
        E_UM_TMO     = 4'd10,
        E_FINAL      = 4'd11
    } err_code_e;

    // Synchronized view of the target status lines.
    typedef struct packed {
        logic [MSEL_W-1:0] msel;
        logic              nconfig;
        logic              nstatus;
        logic              condone;
        logic              condone_oe;
        logic              usermode;
    } pin_stat_t;

    localparam int STAT_W = $bits(pin_stat_t);

    // Levels driven toward the target and the data path.
    typedef struct packed {
        logic nconfig;
        logic nce;
        logic nen_config;
        logic nen_nconfig;
        logic nen_nstatus;
        logic nen_condone;
        logic en_ctrl;
        logic en_data;
        logic stream_go;
        logic dclk;
    } drive_t;

    localparam drive_t DRV_RELEASED = '{
        nconfig: 1'b1, nce: 1'b1, nen_config: 1'b1, nen_nconfig: 1'b1,
        nen_nstatus: 1'b1, nen_condone: 1'b1, en_ctrl: 1'b0,
        en_data: 1'b0, stream_go: 1'b0, dclk: 1'b0
    };

    function automatic drive_t drive_of(seq_state_e s);
        drive_t d;
        d = DRV_RELEASED;
        // overrides taken from OVR up to and including WAIT_UM
        if (s inside {S_OVR, S_CE_LOW, S_WAIT_POST, S_RST_LOW, S_RST_HIGH,
                      S_CHK_CD, S_STREAM, S_WAIT_CD, S_DCLK, S_WAIT_UM}) begin
            d.nen_config  = 1'b0;
            d.nen_nconfig = 1'b0;
        end
        // chip enable asserted one state after the overrides
        if (s inside {S_CE_LOW, S_WAIT_POST, S_RST_LOW, S_RST_HIGH,
                      S_CHK_CD, S_STREAM, S_WAIT_CD, S_DCLK, S_WAIT_UM}) begin
            d.nce = 1'b0;
        end
        if (s == S_RST_LOW) begin
            d.nconfig = 1'b0;
        end
        if (s inside {S_STREAM, S_WAIT_CD, S_DCLK, S_WAIT_UM}) begin
            d.en_ctrl = 1'b1;
            d.en_data = 1'b1;
        end
        d.stream_go = (s == S_STREAM);
        d.dclk      = (s == S_DCLK);
        return d;
    endfunction

    function automatic logic is_rest(seq_state_e s);
        return (s == S_IDLE) || (s == S_DONE) || (s == S_FAIL);
    endfunction

endpackage

// File: rtl/ppcfg_sync.sv
module ppcfg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ppcfg_timer.sv
module ppcfg_timer #(
    parameter int LIMIT = 1 << 24
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)     cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/ppcfg_fsm.sv
module ppcfg_fsm
    import ppcfg_pkg::*;
#(
    parameter int EXTRA_CLKS = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                stream_done_i,
    input  pin_stat_t           stat_i,
    input  logic                tmo_i,
    output logic                tmo_clr_o,
    output drive_t              drv_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [CODE_W-1:0]   code_o
);
    localparam int DW = $clog2(EXTRA_CLKS + 1);
    localparam logic [DW-1:0] DLAST = DW'(EXTRA_CLKS - 1);

    seq_state_e         state_q, state_d;
    err_code_e          fail_code;
    logic               fail;
    logic [DW-1:0]      dclk_q;
    logic [CODE_W-1:0]  code_q;

    always_comb begin
        state_d   = state_q;
        fail      = 1'b0;
        fail_code = E_NONE;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: if (start_i) state_d = S_CHK_MSEL;
            S_CHK_MSEL: begin
                if (stat_i.msel <= MSEL_W'(1)) state_d = S_WAIT_PRE;
                else begin fail = 1'b1; fail_code = E_MSEL; end
            end
            S_WAIT_PRE: begin
                if (stat_i.nconfig && stat_i.nstatus) state_d = S_OVR;
                else if (tmo_i) begin fail = 1'b1; fail_code = E_PRE_PINS; end
            end
            S_OVR:    state_d = S_CE_LOW;
            S_CE_LOW: state_d = S_WAIT_POST;
            S_WAIT_POST: begin
                if (stat_i.nconfig && stat_i.nstatus) state_d = S_RST_LOW;
                else if (tmo_i) begin fail = 1'b1; fail_code = E_POST_PINS; end
            end
            S_RST_LOW: begin
                if (!stat_i.nstatus) state_d = S_RST_HIGH;
                else if (tmo_i) begin fail = 1'b1; fail_code = E_NSTS_LOW; end
            end
            S_RST_HIGH: begin
                if (stat_i.nstatus) state_d = S_CHK_CD;
                else if (tmo_i) begin fail = 1'b1; fail_code = E_NSTS_HIGH; end
            end
            S_CHK_CD: begin
                if (stat_i.condone) begin fail = 1'b1; fail_code = E_CD_HIGH; end
                else if (!stat_i.condone_oe) begin fail = 1'b1; fail_code = E_CD_OE; end
                else state_d = S_STREAM;
            end
            S_STREAM: if (stream_done_i) state_d = S_WAIT_CD;
            S_WAIT_CD: begin
                if (!stat_i.nstatus) begin fail = 1'b1; fail_code = E_NSTS_DROP; end
                else if (stat_i.condone) state_d = S_DCLK;
                else if (tmo_i) begin fail = 1'b1; fail_code = E_CD_TMO; end
            end
            S_DCLK: if (dclk_q == DLAST) state_d = S_WAIT_UM;
            S_WAIT_UM: begin
                if (stat_i.usermode) state_d = S_TEARDOWN;
                else if (tmo_i) begin fail = 1'b1; fail_code = E_UM_TMO; end
            end
            S_TEARDOWN: state_d = S_FINAL;
            S_FINAL: begin
                if (stat_i.usermode && stat_i.condone && stat_i.nstatus)
                    state_d = S_DONE;
                else begin fail = 1'b1; fail_code = E_FINAL; end
            end
            default: state_d = S_IDLE;
        endcase
        if (fail) state_d = S_FAIL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            code_q  <= '0;
            dclk_q  <= '0;
        end else begin
            state_q <= state_d;
            if (is_rest(state_q) && start_i) code_q <= '0;
            else if (fail)                   code_q <= fail_code;
            if (state_q == S_DCLK) dclk_q <= dclk_q + 1'b1;
            else                   dclk_q <= '0;
        end
    end

    assign tmo_clr_o = (state_d != state_q);
    assign drv_o     = drive_of(state_q);
    assign busy_o    = !is_rest(state_q);
    assign done_o    = (state_q == S_DONE) || (state_q == S_FAIL);
    assign code_o    = code_q;
endmodule

// File: rtl/ppcfg_seq.sv
module ppcfg_seq
    import ppcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 1 << 24,
    parameter int EXTRA_CLKS  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stream_done_i,
    input  logic [MSEL_W-1:0] msel_i,
    input  logic              nconfig_pin_i,
    input  logic              nstatus_pin_i,
    input  logic              condone_pin_i,
    input  logic              condone_oe_i,
    input  logic              usermode_i,
    output logic              nconfig_o,
    output logic              nce_o,
    output logic              nen_config_o,
    output logic              nen_nconfig_o,
    output logic              nen_nstatus_o,
    output logic              nen_condone_o,
    output logic              en_cfg_ctrl_o,
    output logic              en_cfg_data_o,
    output logic              stream_go_o,
    output logic              dclk_pulse_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] err_code_o
);
    pin_stat_t raw_stat, sync_stat;
    drive_t    drv;
    logic      tmo_clr, tmo_exp;

    assign raw_stat = '{msel: msel_i, nconfig: nconfig_pin_i,
                        nstatus: nstatus_pin_i, condone: condone_pin_i,
                        condone_oe: condone_oe_i, usermode: usermode_i};

    ppcfg_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_stat),
        .q_o (sync_stat)
    );

    ppcfg_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (tmo_clr),
        .expired_o (tmo_exp)
    );

    ppcfg_fsm #(.EXTRA_CLKS(EXTRA_CLKS)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .stream_done_i (stream_done_i),
        .stat_i        (sync_stat),
        .tmo_i         (tmo_exp),
        .tmo_clr_o     (tmo_clr),
        .drv_o         (drv),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .code_o        (err_code_o)
    );

    assign nconfig_o     = drv.nconfig;
    assign nce_o         = drv.nce;
    assign nen_config_o  = drv.nen_config;
    assign nen_nconfig_o = drv.nen_nconfig;
    assign nen_nstatus_o = drv.nen_nstatus;
    assign nen_condone_o = drv.nen_condone;
    assign en_cfg_ctrl_o = drv.en_ctrl;
    assign en_cfg_data_o = drv.en_data;
    assign stream_go_o   = drv.stream_go;
    assign dclk_pulse_o  = drv.dclk;
endmodule

// File: rtl/ppcfg_seq_chk.sv
module ppcfg_seq_chk #(
    parameter int EXTRA_CLKS = 15
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [3:0] err_code_o,
    input logic       nconfig_o,
    input logic       nce_o,
    input logic       nen_config_o,
    input logic       nen_nconfig_o,
    input logic       nen_nstatus_o,
    input logic       nen_condone_o,
    input logic       en_cfg_ctrl_o,
    input logic       en_cfg_data_o,
    input logic       stream_go_o,
    input logic       dclk_pulse_o
);
    int pulses;

    always_ff @(posedge clk) begin
        if (rst)                        pulses <= 0;
        else if (start_i && !busy_o)    pulses <= 0;
        else if (dclk_pulse_o)          pulses <= pulses + 1;
    end

    p_override_with_ce_r3: assert property (@(posedge clk) disable iff (rst)
        !nce_o |-> (!nen_config_o && !nen_nconfig_o && nen_nstatus_o && nen_condone_o));

    p_override_first_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(nce_o) |-> $past(!nen_config_o && !nen_nconfig_o));

    p_nconfig_low_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
        !nconfig_o |-> !nce_o);

    p_stream_paths_r6: assert property (@(posedge clk) disable iff (rst)
        stream_go_o |-> (en_cfg_ctrl_o && en_cfg_data_o && !nce_o && nconfig_o));

    p_dclk_bound_r7: assert property (@(posedge clk) disable iff (rst)
        pulses <= EXTRA_CLKS);

    p_dclk_full_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_code_o == 4'd0) |-> pulses == EXTRA_CLKS);

    p_released_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (nconfig_o && nce_o && nen_config_o && nen_nconfig_o &&
                    !en_cfg_ctrl_o && !en_cfg_data_o && !busy_o));

    p_busy_ends_in_done_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));
endmodule

bind ppcfg_seq ppcfg_seq_chk #(.EXTRA_CLKS(EXTRA_CLKS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_code_o    (err_code_o),
    .nconfig_o     (nconfig_o),
    .nce_o         (nce_o),
    .nen_config_o  (nen_config_o),
    .nen_nconfig_o (nen_nconfig_o),
    .nen_nstatus_o (nen_nstatus_o),
    .nen_condone_o (nen_condone_o),
    .en_cfg_ctrl_o (en_cfg_ctrl_o),
    .en_cfg_data_o (en_cfg_data_o),
    .stream_go_o   (stream_go_o),
    .dclk_pulse_o  (dclk_pulse_o)
);

// File: tb/test_ppcfg_seq.sv
module test_ppcfg_seq;
    localparam int PERIOD = 10;
    localparam int TMO    = 64;
    localparam int XCLK   = 15;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0, stream_done_i = 1'b0;
    logic [2:0] msel_i = 3'd0;
    logic nconfig_pin_i, nstatus_pin_i, condone_pin_i, condone_oe_i, usermode_i;
    logic nconfig_o, nce_o, nen_config_o, nen_nconfig_o, nen_nstatus_o, nen_condone_o;
    logic en_cfg_ctrl_o, en_cfg_data_o, stream_go_o, dclk_pulse_o, busy_o, done_o;
    logic [3:0] err_code_o;

    // fault injection knobs for the target model
    logic hold_ncfg_low = 0, nsts_force_hi = 0, nsts_force_lo = 0;
    logic cd_force_hi = 0, cd_block = 0, oe_force_lo = 0, um_block = 0;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    ppcfg_seq #(.TIMEOUT_CYC(TMO), .EXTRA_CLKS(XCLK)) i_ppcfg_seq (.*);

    // simple target device model
    logic [2:0] nsts_dly = 3'b111;
    logic cd_q = 0, um_q = 0, streamed = 0;
    int   mdl_dclk = 0;

    always @(posedge clk) begin
        nsts_dly <= {nsts_dly[1:0], nconfig_o};
        if (!nconfig_o) begin
            cd_q <= 0; um_q <= 0; streamed <= 0; mdl_dclk <= 0;
        end else begin
            if (stream_done_i) streamed <= 1;
            if (streamed && !cd_block) cd_q <= 1;
            if (dclk_pulse_o) mdl_dclk <= mdl_dclk + 1;
            if (cd_q && mdl_dclk >= XCLK && !um_block) um_q <= 1;
        end
    end

    assign nconfig_pin_i = nconfig_o && !hold_ncfg_low;
    assign nstatus_pin_i = (nsts_dly[2] || nsts_force_hi) && !nsts_force_lo;
    assign condone_pin_i = cd_q || cd_force_hi;
    assign condone_oe_i  = !oe_force_lo;
    assign usermode_i    = um_q;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_faults();
        hold_ncfg_low = 0; nsts_force_hi = 0; nsts_force_lo = 0;
        cd_force_hi = 0; cd_block = 0; oe_force_lo = 0; um_block = 0;
    endtask

    task automatic check_released(input string tag);
        check({nconfig_o, nce_o, nen_config_o, nen_nconfig_o, nen_nstatus_o,
               nen_condone_o, en_cfg_ctrl_o, en_cfg_data_o},
              8'b1111_1100, tag);
    endtask

    // one full run; drop_after: force nSTATUS low after streaming ends
    task automatic run_seq(input bit drop_after, input bit restart_busy,
                           output int code, output int cycles);
        bit sent = 0;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        cycles = 1;
        while (!done_o && cycles < 3000) begin
            if (stream_go_o && !sent) begin
                sent = 1;
                if (restart_busy) start_i = 1;
                repeat (3) @(negedge clk);
                start_i = 0;
                stream_done_i = 1;
                @(negedge clk);
                stream_done_i = 0;
                if (drop_after) begin
                    @(negedge clk);
                    nsts_force_lo = 1;
                end
                cycles += 5;
            end
            @(negedge clk);
            cycles++;
        end
        code = done_o ? int'(err_code_o) : -1;
    endtask

    task automatic t_reset();
        check(busy_o, 0, "R11 busy after reset");
        check(done_o, 0, "R11 done after reset");
        check(err_code_o, 0, "R11 code after reset");
        check_released("R11 pins after reset");
    endtask

    task automatic t_success(input logic [2:0] m, input string tag);
        int code, cyc;
        clear_faults(); msel_i = m;
        repeat (4) @(negedge clk);
        run_seq(0, 0, code, cyc);
        check(code, 0, {tag, " R8 success code"});
        check(mdl_dclk, XCLK, {tag, " R7 extra clock count"});
        check_released({tag, " R8/R9 released after success"});
        check(busy_o, 0, {tag, " R9 not busy"});
    endtask

    task automatic t_fault(input int exp_code, input bit drop, input string tag);
        int code, cyc;
        run_seq(drop, 0, code, cyc);
        check(code, exp_code, tag);
        check_released({tag, " R9 released after error"});
        clear_faults();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_msel_bad();
        clear_faults(); msel_i = 3'd5;
        repeat (4) @(negedge clk);
        t_fault(1, 0, "R1 msel=5");
        msel_i = 3'd0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pre_timeout();
        int code, cyc;
        clear_faults(); hold_ncfg_low = 1;
        repeat (4) @(negedge clk);
        run_seq(0, 0, code, cyc);
        check(code, 2, "R2 pre-drive pin wait timeout");
        check(int'(cyc >= TMO), 1, "R2 timeout not earlier than limit");
        clear_faults();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_start_busy();
        int code, cyc;
        clear_faults();
        run_seq(0, 1, code, cyc);
        check(code, 0, "R10 restart while busy ignored");
        repeat (5) @(negedge clk);
        check({busy_o, done_o}, 2'b01, "R10 no second run");
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_success(3'd0, "msel0");
        t_success(3'd1, "msel1");
        t_msel_bad();
        t_pre_timeout();
        nsts_force_hi = 1; t_fault(4, 0, "R4 nSTATUS never low");
        cd_force_hi = 1;   t_fault(6, 0, "R5 CONF_DONE high after reset");
        oe_force_lo = 1;   t_fault(7, 0, "R5 CONF_DONE oe low");
        cd_block = 1;      t_fault(8, 1, "R6 nSTATUS drop while waiting");
        cd_block = 1;      t_fault(9, 0, "R6 CONF_DONE timeout");
        um_block = 1;      t_fault(10, 0, "R7 user mode timeout");
        t_start_busy();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule